// File: doc/BRIEF.md
# Post-Configuration Initialization Sequencer

This block covers the stretch between configuration being accepted and the device running user logic. It waits for the configuration-complete flag to rise. It then counts a fixed number of initialization ticks and raises an init-done flag that marks the start of user mode. The number of ticks depends on which device variant is selected.

Two tick sources exist, and both are clock-enable strobes in the one system clock domain. The default is a free-running oscillator tick. The other is an optional user-supplied tick, which lets the board delay user mode for as long as it holds that tick back. The source select and the variant select are captured when the configuration-complete flag rises, and they stay fixed for the rest of that sequence. An active-low restart input aborts the sequence at any point. A fall of the configuration-complete flag during the count also aborts it.

Top module: `init_seq_top`

## Requirements
- R1: While waiting for configuration, ticks from either source are ignored: count_o stays 0 and init_done_o stays 0. Only a 0-to-1 change of cfg_done_i starts a count.
- R2: With variant_i = 0 captured, init_done_o goes high in the cycle after the clock edge that takes the 3185th selected tick.
- R3: With variant_i = 1 captured, init_done_o goes high in the cycle after the clock edge that takes the 3192nd selected tick.
- R4: With use_ext_tick_i = 0 captured, only osc_tick_i advances the count. With use_ext_tick_i = 1 captured, only ext_tick_i advances it.
- R5: While the selected tick is low, the count holds. With the user tick selected and withheld, user mode is never entered.
- R6: init_done_o rises once per sequence and stays high until cfg_restart_ni goes low or reset is applied.
- R7: user_entry_o is a one-cycle pulse in the first cycle in which init_done_o is high.
- R8: While cfg_restart_ni is low, init_done_o is 0 in that same cycle. After the next edge, count_o is 0 and the block waits. A new count needs a fresh 0-to-1 change of cfg_done_i after restart is released.
- R9: Changes to use_ext_tick_i or variant_i after the start of a count have no effect on that count.
- R10: If cfg_done_i falls during the count, count_o reads 0 after the next edge and init_done_o stays low.
- R11: count_o shows the number of ticks taken so far and equals the target while in user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_done_i | input | 1 | Configuration-complete flag |
| cfg_restart_ni | input | 1 | Configuration restart, active low |
| variant_i | input | 1 | Device variant: 0 gives 3185 ticks, 1 gives 3192 ticks |
| use_ext_tick_i | input | 1 | 0 selects the oscillator tick, 1 selects the user tick |
| osc_tick_i | input | 1 | Internal oscillator tick strobe |
| ext_tick_i | input | 1 | User-supplied tick strobe |
| init_done_o | output | 1 | High in user mode |
| user_entry_o | output | 1 | One-cycle pulse on entry to user mode |
| count_o | output | 12 | Initialization ticks counted so far |

## Verification
The rise of cfg_done_i takes effect at the next edge, and count_o reads 0 after that edge. Each tick that is present at an edge shows up in count_o right after that edge. init_done_o and user_entry_o come up in the cycle that follows the edge taking the final tick. A low level on cfg_restart_ni clears init_done_o in the same cycle through a gate, and clears count_o one edge later. The bench drives inputs on falling edges and counts whole cycles from each stimulus. It samples one falling edge after the edge that produces each result, and for the same-cycle restart gate it samples just after the drive.

// File: rtl/init_seq_pkg.sv
package init_seq_pkg;
  localparam int unsigned STD_CYCLES_DEF = 3185;
  localparam int unsigned EXT_CYCLES_DEF = 3192;

  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_WAIT  = 2'd1,
    ST_COUNT = 2'd2,
    ST_USER  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/init_src_sel.sv
module init_src_sel #(
  parameter int unsigned STD_CYCLES = 3185,
  parameter int unsigned EXT_CYCLES = 3192,
  parameter int unsigned CNT_W      = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             use_ext_i,
  input  logic             variant_i,
  input  logic             osc_tick_i,
  input  logic             ext_tick_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] target_o
);
  localparam int unsigned NUM_VAR = 2;

  logic             sel_ext_q;
  logic             variant_q;
  logic [1:0]       ticks;
  logic [CNT_W-1:0] tgt_tab [NUM_VAR];

  for (genvar v = 0; v < NUM_VAR; v++) begin : g_tgt
    assign tgt_tab[v] = (v == 0) ? CNT_W'(STD_CYCLES) : CNT_W'(EXT_CYCLES);
  end

  // selects are frozen at sequence start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_ext_q <= 1'b0;
      variant_q <= 1'b0;
    end else if (load_i) begin
      sel_ext_q <= use_ext_i;
      variant_q <= variant_i;
    end
  end

  assign ticks    = {ext_tick_i, osc_tick_i};
  assign tick_o   = ticks[sel_ext_q];
  assign target_o = tgt_tab[variant_q];

  a_r9_sel_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(target_o));
endmodule

// File: rtl/init_cycle_ctr.sv
module init_cycle_ctr #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] target_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign hit_o = inc_i && (cnt_q == target_i - CNT_W'(1));
  assign cnt_o = cnt_q;

  a_r5_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(cnt_o));
  a_r11_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= target_i);
endmodule

// File: rtl/init_seq_fsm.sv
module init_seq_fsm
  import init_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_done_i,
  input  logic       cfg_restart_ni,
  input  logic       hit_i,
  output seq_state_e state_o,
  output logic       load_o,
  output logic       clr_o,
  output logic       count_en_o,
  output logic       entry_o
);
  seq_state_e state_q, state_d;
  logic       cfg_done_q;
  logic       start;
  logic       entry_q;

  assign start = cfg_done_i && !cfg_done_q;

  always_comb begin
    state_d = state_q;
    if (!cfg_restart_ni) begin
      state_d = ST_WAIT;
    end else begin
      unique case (state_q)
        ST_RESET: state_d = ST_WAIT;
        ST_WAIT:  if (start) state_d = ST_COUNT;
        ST_COUNT: begin
          if (!cfg_done_i) state_d = ST_WAIT;
          else if (hit_i)  state_d = ST_USER;
        end
        ST_USER:  state_d = ST_USER;
        default:  state_d = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_RESET;
      cfg_done_q <= 1'b0;
      entry_q    <= 1'b0;
    end else begin
      state_q    <= state_d;
      cfg_done_q <= cfg_done_i;
      entry_q    <= (state_q == ST_COUNT) && (state_d == ST_USER);
    end
  end

  assign load_o     = (state_q == ST_WAIT) && start && cfg_restart_ni;
  assign clr_o      = !cfg_restart_ni || (state_q == ST_RESET) || (state_q == ST_WAIT) ||
                      ((state_q == ST_COUNT) && !cfg_done_i);
  assign count_en_o = (state_q == ST_COUNT) && cfg_done_i && cfg_restart_ni;
  assign entry_o    = entry_q;
  assign state_o    = state_q;

  a_r1_wait_for_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !cfg_done_i) |=> (state_q == ST_WAIT));
  a_r10_drop_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COUNT && !cfg_done_i) |=> (state_q == ST_WAIT));
  a_r6_user_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_USER && cfg_restart_ni) |=> (state_q == ST_USER));
  a_r7_entry_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_o |=> !entry_o);
endmodule

// File: rtl/init_seq_top.sv
module init_seq_top
  import init_seq_pkg::*;
#(
  parameter int unsigned STD_CYCLES = STD_CYCLES_DEF,
  parameter int unsigned EXT_CYCLES = EXT_CYCLES_DEF,
  localparam int unsigned MAX_CYC   = (STD_CYCLES > EXT_CYCLES) ? STD_CYCLES : EXT_CYCLES,
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_done_i,
  input  logic             cfg_restart_ni,
  input  logic             variant_i,
  input  logic             use_ext_tick_i,
  input  logic             osc_tick_i,
  input  logic             ext_tick_i,
  output logic             init_done_o,
  output logic             user_entry_o,
  output logic [CNT_W-1:0] count_o
);
  seq_state_e       state;
  logic             load, clr, count_en, hit, tick;
  logic [CNT_W-1:0] target;

  init_src_sel #(.STD_CYCLES(STD_CYCLES), .EXT_CYCLES(EXT_CYCLES), .CNT_W(CNT_W)) u_src (
    .clk_i, .rst_ni, .load_i(load), .use_ext_i(use_ext_tick_i), .variant_i,
    .osc_tick_i, .ext_tick_i, .tick_o(tick), .target_o(target)
  );

  init_cycle_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i, .rst_ni, .clr_i(clr), .inc_i(count_en && tick), .target_i(target),
    .cnt_o(count_o), .hit_o(hit)
  );

  init_seq_fsm u_fsm (
    .clk_i, .rst_ni, .cfg_done_i, .cfg_restart_ni, .hit_i(hit),
    .state_o(state), .load_o(load), .clr_o(clr), .count_en_o(count_en), .entry_o(user_entry_o)
  );

  // restart gates done in the same cycle
  assign init_done_o = (state == ST_USER) && cfg_restart_ni;

  a_r8_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_restart_ni |=> (count_o == '0 && !user_entry_o));
  a_r11_user_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> (count_o == target));
  a_r7_entry_in_user: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (user_entry_o && cfg_restart_ni) |-> init_done_o);
endmodule

// File: tb/tb_init_seq_top.sv
module tb_init_seq_top;
  localparam int STD = 3185;
  localparam int EXT = 3192;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_done, restart_n, variant, use_ext, osc_tick, ext_tick;
  logic        init_done, user_entry;
  logic [11:0] count;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  init_seq_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_done_i(cfg_done), .cfg_restart_ni(restart_n),
    .variant_i(variant), .use_ext_tick_i(use_ext), .osc_tick_i(osc_tick),
    .ext_tick_i(ext_tick), .init_done_o(init_done), .user_entry_o(user_entry),
    .count_o(count)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; cfg_done = 0; restart_n = 1; variant = 0; use_ext = 0;
    osc_tick = 0; ext_tick = 0;
    step(2);
    rst_ni = 1'b1;
    step(2);
  endtask

  task automatic t_reset();
    do_reset();
    chk_eq("R6 reset done", int'(init_done), 0);
    chk_eq("R7 reset entry", int'(user_entry), 0);
    chk_eq("R11 reset count", int'(count), 0);
  endtask

  task automatic t_wait_ignores();
    do_reset();
    osc_tick = 1; ext_tick = 1;
    step(100);
    chk_eq("R1 count while waiting", int'(count), 0);
    chk_eq("R1 done while waiting", int'(init_done), 0);
  endtask

  task automatic t_run(input bit var_sel, input int tgt, input string req);
    do_reset();
    variant = var_sel; osc_tick = 1;
    cfg_done = 1;
    step(1);
    chk_eq({req, " start count"}, int'(count), 0);
    step(tgt - 1);
    chk_eq({req, " count before end"}, int'(count), tgt - 1);
    chk_eq({req, " done before end"}, int'(init_done), 0);
    step(1);
    chk_eq({req, " done at end"}, int'(init_done), 1);
    chk_eq("R7 entry pulse", int'(user_entry), 1);
    chk_eq("R11 count at target", int'(count), tgt);
    step(1);
    chk_eq("R7 entry one cycle", int'(user_entry), 0);
    step(50);
    chk_eq("R6 done sticky", int'(init_done), 1);
  endtask

  task automatic t_ext_tick();
    do_reset();
    use_ext = 1; osc_tick = 1; ext_tick = 0;
    cfg_done = 1;
    step(60);
    chk_eq("R5 no user tick holds", int'(count), 0);
    chk_eq("R5 no user tick no done", int'(init_done), 0);
    for (int i = 1; i <= STD; i++) begin
      ext_tick = 1; step(1);
      ext_tick = 0; step(1);
      if (i == 100) chk_eq("R4 user ticks only", int'(count), 100);
    end
    chk_eq("R4 user tick done", int'(init_done), 1);
    chk_eq("R11 user tick count", int'(count), STD);
  endtask

  task automatic t_latch();
    do_reset();
    osc_tick = 1; cfg_done = 1;
    step(11);
    chk_eq("R9 early count", int'(count), 10);
    use_ext = 1; variant = 1; ext_tick = 0;
    step(STD - 11);
    chk_eq("R9 count keeps osc", int'(count), STD - 1);
    step(1);
    chk_eq("R9 target kept", int'(init_done), 1);
  endtask

  task automatic t_restart();
    do_reset();
    osc_tick = 1; cfg_done = 1;
    step(501);
    chk_eq("R8 pre restart", int'(count), 500);
    restart_n = 0;
    step(1);
    chk_eq("R8 count cleared", int'(count), 0);
    chk_eq("R8 done low", int'(init_done), 0);
    step(10);
    restart_n = 1;
    step(20);
    chk_eq("R8 needs new rise", int'(count), 0);
    cfg_done = 0; step(1);
    cfg_done = 1; step(1);
    step(5);
    chk_eq("R8 recount", int'(count), 5);
    step(STD - 5);
    chk_eq("R8 done again", int'(init_done), 1);
    restart_n = 0;
    #1;
    chk_eq("R8 done gated same cycle", int'(init_done), 0);
    step(1);
    chk_eq("R8 user restart count", int'(count), 0);
    chk_eq("R8 user restart entry", int'(user_entry), 0);
    restart_n = 1;
  endtask

  task automatic t_cfg_drop();
    do_reset();
    osc_tick = 1; cfg_done = 1;
    step(301);
    chk_eq("R10 mid count", int'(count), 300);
    cfg_done = 0;
    step(1);
    chk_eq("R10 count cleared", int'(count), 0);
    step(20);
    chk_eq("R10 stays waiting", int'(count), 0);
    chk_eq("R10 no done", int'(init_done), 0);
  endtask

  initial begin
    t_reset();
    t_wait_ignores();
    t_run(1'b0, STD, "R2");
    t_run(1'b1, EXT, "R3");
    t_ext_tick();
    t_latch();
    t_restart();
    t_cfg_drop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule